// File: doc/BRIEF.md
# Transmit Source Select with Skip Scheduling

This block decides, on every symbol clock, which of four streams feeds the lane striper. The four streams are packet symbols from the link layer, training ordered sets, clock-compensation skip sets and pseudo-random idle data. It emits one 8-bit symbol per cycle. Each symbol carries a control flag and a tag that names the stream it came from. Packet symbols enter through a small FIFO with a valid/ready handshake. Each entry is a byte plus its control flag.

A symbol-time counter times the skip sets. Once a skip set is due, it is held back until the current packet or ordered set has ended. Training overrides every other stream while it is requested. Otherwise the order is:

1. A due skip set at a boundary.
2. Packet data.
3. Idle.

Back-pressure works as follows. A symbol is accepted on any cycle where `in_valid` and `in_ready` are both high. `in_ready` is low exactly when the FIFO holds 16 entries. The link layer must keep `in_data`/`in_k` stable until the symbol is accepted. A symbol offered while `in_ready` is low is dropped and has no effect.

Top module: `tx_src_sel`

## Requirements
- R1: The packet FIFO holds 16 entries. `in_ready` is low while all 16 are occupied. A symbol offered while `in_ready` is low is not stored. Stored symbols leave in arrival order.
- R2: While `train_active` is high, every output symbol has source tag 3. The output runs in repeating sets of 16 symbols: first COM (0xBC, K=1), then 15 data symbols with the value 0x4A, or 0x45 when `train_ts2` is high. While training, the FIFO is not read and the skip counter stays at zero.
- R3: A skip set is four symbols with source tag 2: COM (0xBC, K=1) followed by three SKP (0x1C, K=1) on consecutive cycles.
- R4: The skip counter restarts at zero on the cycle a skip set starts and while training. A skip set starts on the first boundary cycle on which the counter has reached 4352. With continuous idle traffic, skip sets start exactly 4353 symbol times apart. The first skip set after training ends starts on the 4353rd symbol after training ends.
- R5: No skip symbol is emitted between a start delimiter (SDP 0xFB or SLP 0x5C, K=1) and the end delimiter that closes it (EGP 0xFD or EBP 0xFE, K=1). A skip set that became due during a packet starts on the symbol directly after the end delimiter.
- R6: A skip set starts before the skip counter reaches 4608.
- R7: Packet symbols are output with source tag 1, with their byte and control flag unchanged. A symbol accepted at a clock edge appears on the output after the next edge, provided no higher-priority source is active then.
- R8: When no higher source is active and the FIFO is empty, idle data is sent with source tag 0 and K=0. The bytes come from an 11-bit shift register:
  - It starts at 0x7FF after reset.
  - Each idle symbol sends the low 8 bits of the register.
  - After each idle symbol the register shifts left by one bit, taking in bit 10 XOR bit 8.
  - The register does not advance on any other symbol.
- R9: If the FIFO runs empty inside a packet, idle symbols fill the gap and a due skip set stays deferred.
- R10: During and directly after reset, `out_src` is 0, `out_sym` is 0x00, `out_k` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Active-low synchronous reset |
| train_active | input | 1 | Forces the training ordered-set stream |
| train_ts2 | input | 1 | Selects the second training set identifier |
| in_valid | input | 1 | Link-layer symbol valid |
| in_ready | output | 1 | FIFO can accept a symbol |
| in_data | input | 8 | Link-layer symbol byte |
| in_k | input | 1 | Link-layer symbol is a control symbol |
| out_sym | output | 8 | Selected symbol byte |
| out_k | output | 1 | Selected symbol is a control symbol |
| out_src | output | 2 | Source tag: 0 idle, 1 packet, 2 skip, 3 training |

## Verification
The assertions check the cycle-local rules on every cycle:
- training takes over the output one cycle after it is requested;
- COM is always followed by SKP;
- no skip symbol appears while a packet is open;
- idle symbols never carry the control flag;
- the FIFO never overfills;
- the skip counter never reaches its deadline.

Only the bench scenarios can show the properties that need exact values over time. These are the 4353-symbol skip spacing, the deferral of a due skip set past an underrunning packet to the cycle after its end delimiter, the idle byte sequence, and the ordering and drop behaviour of the FIFO under back-pressure.

// File: rtl/tx_src_pkg.sv
package tx_src_pkg;

  typedef enum logic [1:0] {
    SRC_IDLE  = 2'd0,
    SRC_PKT   = 2'd1,
    SRC_SKIP  = 2'd2,
    SRC_TRAIN = 2'd3
  } src_e;

  localparam logic [7:0] SYM_COM    = 8'hBC;
  localparam logic [7:0] SYM_SKP    = 8'h1C;
  localparam logic [7:0] SYM_SDP    = 8'hFB;
  localparam logic [7:0] SYM_SLP    = 8'h5C;
  localparam logic [7:0] SYM_EGP    = 8'hFD;
  localparam logic [7:0] SYM_EBP    = 8'hFE;
  localparam logic [7:0] SYM_TS1_ID = 8'h4A;
  localparam logic [7:0] SYM_TS2_ID = 8'h45;

  localparam int SYM_W = 9;

endpackage

// File: rtl/tx_pkt_fifo.sv
module tx_pkt_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam bit POW2 = ((1 << PW) == DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
  logic [CW-1:0]    count;
  logic             push, pop, full;

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign wr_ready = !full;
  assign push     = wr_valid && !full;
  assign pop      = rd_en && !empty;
  assign rd_data  = mem[rd_ptr];

  generate
    if (POW2) begin : g_wrap_free
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
    end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_nxt;
      if (pop)  rd_ptr <= rd_nxt;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R1: occupancy never passes the depth
  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R1: a full FIFO that is not read stays full and refuses input
  assert_full_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_en) |=> (!wr_ready));

endmodule

// File: rtl/tx_skip_sched.sv
module tx_skip_sched #(
  parameter int SKIP_MIN = 4352,
  parameter int SKIP_MAX = 4608
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic start,
  output logic due
);
  localparam int CW = $clog2(SKIP_MAX + 1);

  logic [CW-1:0] cnt;

  assign due = (cnt >= CW'(SKIP_MIN));

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (hold || start)  cnt <= '0;
    else if (cnt != CW'(SKIP_MAX)) cnt <= cnt + 1'b1;
  end

  // R6: a skip set must begin before the deadline count is reached
  assert_skip_deadline_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(SKIP_MAX));

  // R4: the selector only starts a skip set once the minimum spacing elapsed
  assert_skip_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (cnt >= CW'(SKIP_MIN)));

endmodule

// File: rtl/tx_idle_lfsr.sv
module tx_idle_lfsr #(
  parameter logic [10:0] SEED = 11'h7FF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  output logic [7:0] idle_byte
);
  logic [10:0] st;

  assign idle_byte = st[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n)   st <= SEED;
    else if (adv) st <= {st[9:0], st[10] ^ st[8]};
  end

  // R8: the generator never sits in the all-zero lock-up state
  assert_lfsr_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
    st != 11'h000);

endmodule

// File: rtl/tx_train_gen.sv
module tx_train_gen
  import tx_src_pkg::*;
#(
  parameter int TS_LEN = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       use_ts2,
  output logic [7:0] ts_sym,
  output logic       ts_k
);
  localparam int IW = $clog2(TS_LEN);

  logic [IW-1:0] idx;

  assign ts_k   = (idx == '0);
  assign ts_sym = ts_k ? SYM_COM : (use_ts2 ? SYM_TS2_ID : SYM_TS1_ID);

  always_ff @(posedge clk) begin
    if (!rst_n || !active)           idx <= '0;
    else if (idx == IW'(TS_LEN - 1)) idx <= '0;
    else                             idx <= idx + 1'b1;
  end

endmodule

// File: rtl/tx_src_sel.sv
module tx_src_sel
  import tx_src_pkg::*;
#(
  parameter int          FIFO_DEPTH = 16,
  parameter int          SKIP_MIN   = 4352,
  parameter int          SKIP_MAX   = 4608,
  parameter int          TS_LEN     = 16,
  parameter logic [10:0] IDLE_SEED  = 11'h7FF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       train_active,
  input  logic       train_ts2,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_k,
  output logic [7:0] out_sym,
  output logic       out_k,
  output logic [1:0] out_src
);
  localparam int SKIP_LEN = 4;
  localparam int SPW      = $clog2(SKIP_LEN);

  logic [SYM_W-1:0] head;
  logic             fifo_empty, pop;
  logic             due, skip_start;
  logic [7:0]       lfsr_byte;
  logic             lfsr_adv;
  logic [7:0]       ts_sym;
  logic             ts_k;
  logic             skip_busy, in_pkt;
  logic [SPW-1:0]   skip_pos;
  logic             head_open, head_close;

  src_e       sel_src, src_q;
  logic [7:0] sel_sym;
  logic       sel_k;

  tx_pkt_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(SYM_W)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(in_valid), .wr_ready(in_ready), .wr_data({in_k, in_data}),
    .rd_en(pop), .rd_data(head), .empty(fifo_empty)
  );

  tx_skip_sched #(.SKIP_MIN(SKIP_MIN), .SKIP_MAX(SKIP_MAX)) u_sched (
    .clk(clk), .rst_n(rst_n), .hold(train_active), .start(skip_start), .due(due)
  );

  tx_idle_lfsr #(.SEED(IDLE_SEED)) u_idle (
    .clk(clk), .rst_n(rst_n), .adv(lfsr_adv), .idle_byte(lfsr_byte)
  );

  tx_train_gen #(.TS_LEN(TS_LEN)) u_train (
    .clk(clk), .rst_n(rst_n), .active(train_active), .use_ts2(train_ts2),
    .ts_sym(ts_sym), .ts_k(ts_k)
  );

  assign head_open  = head[8] && (head[7:0] == SYM_SDP || head[7:0] == SYM_SLP);
  assign head_close = head[8] && (head[7:0] == SYM_EGP || head[7:0] == SYM_EBP);

  always_comb begin
    sel_src    = SRC_IDLE;
    sel_sym    = lfsr_byte;
    sel_k      = 1'b0;
    pop        = 1'b0;
    skip_start = 1'b0;
    lfsr_adv   = 1'b0;
    if (train_active) begin
      sel_src = SRC_TRAIN;
      sel_sym = ts_sym;
      sel_k   = ts_k;
    end else if (skip_busy) begin
      sel_src = SRC_SKIP;
      sel_sym = SYM_SKP;
      sel_k   = 1'b1;
    end else if (due && !in_pkt) begin
      sel_src    = SRC_SKIP;
      sel_sym    = SYM_COM;
      sel_k      = 1'b1;
      skip_start = 1'b1;
    end else if (!fifo_empty) begin
      sel_src = SRC_PKT;
      sel_sym = head[7:0];
      sel_k   = head[8];
      pop     = 1'b1;
    end else begin
      lfsr_adv = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q     <= SRC_IDLE;
      out_sym   <= 8'h00;
      out_k     <= 1'b0;
      skip_busy <= 1'b0;
      skip_pos  <= '0;
      in_pkt    <= 1'b0;
    end else begin
      src_q   <= sel_src;
      out_sym <= sel_sym;
      out_k   <= sel_k;
      if (train_active) begin
        skip_busy <= 1'b0;
        skip_pos  <= '0;
        in_pkt    <= 1'b0;
      end else if (skip_busy) begin
        if (skip_pos == SPW'(SKIP_LEN - 1)) begin
          skip_busy <= 1'b0;
          skip_pos  <= '0;
        end else begin
          skip_pos <= skip_pos + 1'b1;
        end
      end else if (skip_start) begin
        skip_busy <= 1'b1;
        skip_pos  <= SPW'(1);
      end else if (pop) begin
        if (head_open)       in_pkt <= 1'b1;
        else if (head_close) in_pkt <= 1'b0;
      end
    end
  end

  assign out_src = src_q;

  // R2: a training request owns the output from the next symbol on
  assert_train_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    train_active |=> (out_src == SRC_TRAIN));

  // R3: a skip COM is followed by SKP unless training cuts in
  assert_skip_body_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_src == SRC_SKIP && out_sym == SYM_COM && !train_active)
      |=> (out_src == SRC_SKIP && out_sym == SYM_SKP && out_k));

  // R5: no skip symbol while a packet is open
  assert_no_skip_in_pkt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pkt && !train_active) |=> (out_src != SRC_SKIP));

  // R8: idle symbols are always data symbols
  assert_idle_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_src == SRC_IDLE) |-> !out_k);

endmodule

// File: tb/tx_src_sel_tb_top.sv
module tx_src_sel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SKIP_MIN   = 4352;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       train_active, train_ts2;
  logic       in_valid, in_ready, in_k;
  logic [7:0] in_data;
  logic [7:0] out_sym;
  logic       out_k;
  logic [1:0] out_src;

  int  n_cmp = 0;
  int  n_err = 0;
  bit  mon_on = 1'b0;
  bit  done = 1'b0;
  logic [10:0] mdl_lfsr = 11'h7FF;
  bit  b_in_pkt = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_src_sel dut_i (
    .clk(clk), .rst_n(rst_n), .train_active(train_active), .train_ts2(train_ts2),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_k(in_k),
    .out_sym(out_sym), .out_k(out_k), .out_src(out_src)
  );

  typedef struct packed {
    logic       v;
    logic       k;
    logic [7:0] d;
    logic [1:0] es;
    logic       ek;
    logic [7:0] ed;
  } vec_t;

  // Stimulus per cycle and expected output after that cycle's edge (R7, R8)
  localparam vec_t VEC [10] = '{
    '{1'b1, 1'b1, 8'hFB, 2'd0, 1'b0, 8'h00},
    '{1'b1, 1'b0, 8'h11, 2'd1, 1'b1, 8'hFB},
    '{1'b1, 1'b0, 8'h22, 2'd1, 1'b0, 8'h11},
    '{1'b1, 1'b1, 8'hFD, 2'd1, 1'b0, 8'h22},
    '{1'b0, 1'b0, 8'h00, 2'd1, 1'b1, 8'hFD},
    '{1'b0, 1'b0, 8'h00, 2'd0, 1'b0, 8'h00},
    '{1'b1, 1'b1, 8'h5C, 2'd0, 1'b0, 8'h00},
    '{1'b1, 1'b1, 8'hFE, 2'd1, 1'b1, 8'h5C},
    '{1'b0, 1'b0, 8'h00, 2'd1, 1'b1, 8'hFE},
    '{1'b0, 1'b0, 8'h00, 2'd0, 1'b0, 8'h00}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic push_tick(input logic k, input logic [7:0] d);
    in_valid = 1'b1; in_k = k; in_data = d;
    tick();
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    mon_on = 1'b0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  endtask

  // Monitor: idle byte sequence (R8) and no skip inside a packet (R5)
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_src == 2'd0) begin
        chk(out_sym == mdl_lfsr[7:0] && !out_k, "R8 idle byte", {out_k, out_sym}, {1'b0, mdl_lfsr[7:0]});
        mdl_lfsr = {mdl_lfsr[9:0], mdl_lfsr[10] ^ mdl_lfsr[8]};
      end
      if (b_in_pkt)
        chk(out_src != 2'd2, "R5 skip inside packet", out_src, 2'd1);
      if (out_src == 2'd3) b_in_pkt = 1'b0;
      else if (out_src == 2'd1 && out_k && (out_sym == 8'hFB || out_sym == 8'h5C)) b_in_pkt = 1'b1;
      else if (out_src == 2'd1 && out_k && (out_sym == 8'hFD || out_sym == 8'hFE)) b_in_pkt = 1'b0;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      finish_run();
    end
  end

  initial begin
    int n_since;
    rst_n = 1'b0; train_active = 1'b0; train_ts2 = 1'b0;
    in_valid = 1'b0; in_k = 1'b0; in_data = 8'h00;
    repeat (3) tick();
    // R10: reset state
    chk(out_src == 2'd0 && out_sym == 8'h00 && !out_k && in_ready, "R10 reset state",
        {in_ready, out_k, out_src, out_sym}, {1'b1, 1'b0, 2'd0, 8'h00});
    rst_n = 1'b1;
    tick();
    mon_on = 1'b1;

    // Table walk: packets and idle interleave (R7)
    for (int i = 0; i < 10; i++) begin
      in_valid = VEC[i].v; in_k = VEC[i].k; in_data = VEC[i].d;
      tick();
      in_valid = 1'b0;
      chk(out_src == VEC[i].es && out_k == VEC[i].ek &&
          (VEC[i].es == 2'd0 || out_sym == VEC[i].ed), "R7 packet stream",
          {out_src, out_k, out_sym}, {VEC[i].es, VEC[i].ek, VEC[i].ed});
    end

    // Training sets (R2)
    train_active = 1'b1;
    for (int i = 0; i < 16; i++) begin
      tick();
      chk(out_src == 2'd3 && out_k == (i == 0) && out_sym == ((i == 0) ? 8'hBC : 8'h4A),
          "R2 TS1 set", {out_src, out_k, out_sym}, {2'd3, (i == 0), ((i == 0) ? 8'hBC : 8'h4A)});
    end
    train_ts2 = 1'b1;
    tick();
    chk(out_src == 2'd3 && out_k && out_sym == 8'hBC, "R2 TS2 COM", {out_src, out_k, out_sym}, {2'd3, 1'b1, 8'hBC});
    tick();
    chk(out_src == 2'd3 && !out_k && out_sym == 8'h45, "R2 TS2 id", {out_src, out_k, out_sym}, {2'd3, 1'b0, 8'h45});

    // Back-pressure while training holds the FIFO (R1)
    for (int i = 0; i < 17; i++) push_tick(1'b0, 8'h40 + 8'(i));
    chk(!in_ready, "R1 ready low when full", in_ready, 0);
    chk(out_src == 2'd3, "R2 training over queued packets", out_src, 2'd3);
    train_active = 1'b0; train_ts2 = 1'b0;
    n_since = 0;
    for (int i = 0; i < 16; i++) begin
      tick(); n_since++;
      chk(out_src == 2'd1 && !out_k && out_sym == 8'h40 + 8'(i), "R1 drain order",
          {out_src, out_sym}, {2'd1, 8'h40 + 8'(i)});
    end
    tick(); n_since++;
    chk(out_src == 2'd0, "R1 rejected symbol absent", {out_src, out_sym}, {2'd0, 8'h00});

    // First skip after training (R4)
    for (int g = 0; g < 6000 && out_src != 2'd2; g++) begin tick(); n_since++; end
    chk(out_src == 2'd2 && out_k && out_sym == 8'hBC && n_since == SKIP_MIN + 1,
        "R4 first skip timing", n_since, SKIP_MIN + 1);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(out_src == 2'd2 && out_k && out_sym == 8'h1C, "R3 SKP body",
          {out_src, out_k, out_sym}, {2'd2, 1'b1, 8'h1C});
    end
    n_since = 3;
    tick(); n_since++;
    for (int g = 0; g < 6000 && out_src != 2'd2; g++) begin tick(); n_since++; end
    chk(out_src == 2'd2 && out_sym == 8'hBC && n_since == SKIP_MIN + 1,
        "R4 idle skip spacing", n_since, SKIP_MIN + 1);

    // Deferral past an underrunning packet (R5, R9)
    repeat (SKIP_MIN - 5) tick();
    push_tick(1'b1, 8'hFB);
    push_tick(1'b0, 8'h31);
    chk(out_src == 2'd1 && out_k && out_sym == 8'hFB, "R7 SDP out", {out_src, out_sym}, {2'd1, 8'hFB});
    push_tick(1'b0, 8'h32);
    tick();
    chk(out_src == 2'd1 && out_sym == 8'h32, "R7 body out", {out_src, out_sym}, {2'd1, 8'h32});
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(out_src == 2'd0, "R9 underrun fill", out_src, 2'd0);
    end
    push_tick(1'b1, 8'hFD);
    chk(out_src == 2'd0, "R9 deferred skip", out_src, 2'd0);
    tick();
    chk(out_src == 2'd1 && out_k && out_sym == 8'hFD, "R5 EGP out", {out_src, out_k, out_sym}, {2'd1, 1'b1, 8'hFD});
    tick();
    chk(out_src == 2'd2 && out_k && out_sym == 8'hBC, "R5 skip after end", {out_src, out_k, out_sym}, {2'd2, 1'b1, 8'hBC});
    repeat (4) tick();
    chk(out_src == 2'd0, "R8 idle resumes", out_src, 2'd0);

    done = 1'b1;
    finish_run();
  end

endmodule